// File: doc/BRIEF.md
# In-Order Pipeline Hazard Interlock

This block is the interlock controller for a four-stage in-order pipeline (fetch, decode, execute, writeback) that has no result forwarding. Instructions come in two classes, ADD and MUL. Each names one destination register and two source registers. The execute stage is pipelined and has a different depth for each class. Operations only travel through the stage registers and the latency slots. No arithmetic is done.

A scoreboard holds one pending-write bit per register. An instruction waits in decode while any register it reads or writes still has a write outstanding. It also waits if its result would reach writeback in the same cycle as an older, longer operation. The front end supplies one instruction per cycle on the input port and holds it whenever `stall_o` is high. The block reports each issue and each stalled decode cycle. It raises a done flag once the program has drained, and it keeps a running cycle count up to that point.

Top module: `inorder_interlock`

## Requirements
- R1: While `rst_ni` is low, `stall_o`, `issue_o` and `done_o` are 0 and `cycle_cnt_o` is 0.
- R2: An instruction is captured into fetch at a rising edge where `in_valid_i` is 1 and `stall_o` is 0. The opcode encoding is `in_op_i` 0 = ADD and 1 = MUL. The instruction enters decode at the next edge, and with no hazard it issues at the edge after that. Issue is strictly in program order.
- R3: An issued ADD spends 4 cycles in execute and a MUL spends 6, each followed by one writeback cycle. A lone ADD program finishes with a count of 8, and a lone MUL program with a count of 10.
- R4: An instruction that reads a register with a pending write stays in decode. It issues in the cycle after the producer's writeback cycle, at issue edge of producer + latency + 2. This holds for either source field.
- R5: An instruction whose destination has a pending write waits in the same way as in R4.
- R6: An ADD is held in decode for one cycle when issuing it would place its writeback in the same cycle as an earlier MUL. At most one instruction writes back per cycle.
- R7: Independent instructions issue on consecutive cycles with no stall.
- R8: `done_o` goes high at the edge that ends the last writeback, once the instruction flagged by `in_last_i` has issued. It stays high until reset. An ADD may complete before an older MUL.
- R9: `cycle_cnt_o` increases by one at every edge after reset, up to and including the edge where `done_o` rises. It holds its value after that.
- R10: Register 0 is tracked like any other register.
- R11: `stall_o` and `issue_o` are never high together. While `stall_o` is high, the decoded instruction and the input are held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Instruction present on the input |
| in_op_i | input | 1 | Opcode: 0 ADD, 1 MUL |
| in_rd_i | input | REG_W | Destination register |
| in_rs1_i | input | REG_W | First source register |
| in_rs2_i | input | REG_W | Second source register |
| in_last_i | input | 1 | Marks the final instruction of the program |
| stall_o | output | 1 | Decode is held; the front end must keep its input |
| issue_o | output | 1 | Decode sends an instruction to execute this cycle |
| done_o | output | 1 | Program has fully drained |
| cycle_cnt_o | output | CNT_W | Cycles from reset to completion |

## Verification
Lone ADD and lone MUL programs pin down the base latency of each class. Back-to-back independent ADDs show that issue runs at one per cycle with no bubbles. Dependent pairs are tested in several forms: ADD feeding ADD, MUL feeding ADD through the second source, a write-after-write pair, and a chain through register 0. Their stall counts and finish times separate the R4 and R5 waits from the 4- and 6-cycle windows, and they catch any special case for register 0. A MUL followed by two independent ADDs exposes the one-cycle writeback-collision hold. A MUL followed by a last ADD shows that completion waits for the older, slower operation.

// File: rtl/ilk_pkg.sv
package ilk_pkg;
  typedef enum logic {OP_ADD = 1'b0, OP_MUL = 1'b1} op_e;
endpackage

// File: rtl/ilk_scoreboard.sv
module ilk_scoreboard #(
  parameter int REG_W = 3,
  localparam int NREG = 1 << REG_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             set_en_i,
  input  logic [REG_W-1:0] set_idx_i,
  input  logic             clr_en_i,
  input  logic [REG_W-1:0] clr_idx_i,
  output logic [NREG-1:0]  busy_o
);
  logic [NREG-1:0] busy_q;

  for (genvar r = 0; r < NREG; r++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) busy_q[r] <= 1'b0;
      else if (set_en_i && set_idx_i == REG_W'(r)) busy_q[r] <= 1'b1;
      else if (clr_en_i && clr_idx_i == REG_W'(r)) busy_q[r] <= 1'b0;
    end
  end

  assign busy_o = busy_q;

  // R4: every writeback retires a write that was pending
  a_r4_clear_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_en_i |-> busy_q[clr_idx_i]);
  // R5: no second write is issued to a register already pending
  a_r5_no_double_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_en_i |-> !busy_q[set_idx_i]);
endmodule

// File: rtl/ilk_exec_pipe.sv
module ilk_exec_pipe
  import ilk_pkg::*;
#(
  parameter int REG_W   = 3,
  parameter int ADD_LAT = 4,
  parameter int MUL_LAT = 6,
  localparam int NSLOT   = MUL_LAT,
  localparam int ADD_ENT = MUL_LAT - ADD_LAT
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             issue_i,
  input  op_e              op_i,
  input  logic [REG_W-1:0] rd_i,
  output logic             wb_conflict_o,
  output logic             busy_o,
  output logic             wb_valid_o,
  output logic [REG_W-1:0] wb_rd_o
);
  logic [NSLOT-1:0] slot_v;
  logic [REG_W-1:0] slot_rd [NSLOT];
  logic             wb_v_q;
  logic [REG_W-1:0] wb_rd_q;

  // entry slot index for the incoming op; MUL always enters slot 0
  function automatic int entry_of(op_e op);
    return (op == OP_MUL) ? 0 : ADD_ENT;
  endfunction

  if (ADD_ENT > 0) begin : g_conflict
    // ADD would land in a slot an older op shifts into
    assign wb_conflict_o = (op_i == OP_ADD) && slot_v[ADD_ENT-1];
  end else begin : g_no_conflict
    assign wb_conflict_o = 1'b0;
  end

  for (genvar k = 0; k < NSLOT; k++) begin : g_slot
    logic ins;
    assign ins = issue_i && (entry_of(op_i) == k);
    if (k == 0) begin : g_head
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          slot_v[k]  <= 1'b0;
          slot_rd[k] <= '0;
        end else begin
          slot_v[k]  <= ins;
          slot_rd[k] <= ins ? rd_i : '0;
        end
      end
    end else begin : g_body
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          slot_v[k]  <= 1'b0;
          slot_rd[k] <= '0;
        end else begin
          slot_v[k]  <= slot_v[k-1] | ins;
          slot_rd[k] <= ins ? rd_i : slot_rd[k-1];
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wb_v_q  <= 1'b0;
      wb_rd_q <= '0;
    end else begin
      wb_v_q  <= slot_v[NSLOT-1];
      wb_rd_q <= slot_rd[NSLOT-1];
    end
  end

  assign busy_o     = |slot_v;
  assign wb_valid_o = wb_v_q;
  assign wb_rd_o    = wb_rd_q;

  // R6: a slot receiving an issued op was empty in its upstream neighbour
  a_r6_no_slot_merge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_i && op_i == OP_ADD && ADD_ENT > 0) |-> !wb_conflict_o);
  // R3: writeback follows the last execute slot by one cycle
  a_r3_wb_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_v[NSLOT-1] |=> wb_v_q);
endmodule

// File: rtl/ilk_front.sv
module ilk_front
  import ilk_pkg::*;
#(
  parameter int REG_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             advance_i,
  input  logic             in_valid_i,
  input  op_e              in_op_i,
  input  logic [REG_W-1:0] in_rd_i,
  input  logic [REG_W-1:0] in_rs1_i,
  input  logic [REG_W-1:0] in_rs2_i,
  input  logic             in_last_i,
  output logic             d_valid_o,
  output op_e              d_op_o,
  output logic [REG_W-1:0] d_rd_o,
  output logic [REG_W-1:0] d_rs1_o,
  output logic [REG_W-1:0] d_rs2_o,
  output logic             d_last_o
);
  logic             f_v;
  op_e              f_op;
  logic [REG_W-1:0] f_rd, f_rs1, f_rs2;
  logic             f_last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      f_v <= 1'b0; f_op <= OP_ADD; f_rd <= '0; f_rs1 <= '0; f_rs2 <= '0; f_last <= 1'b0;
      d_valid_o <= 1'b0; d_op_o <= OP_ADD; d_rd_o <= '0; d_rs1_o <= '0; d_rs2_o <= '0;
      d_last_o <= 1'b0;
    end else if (advance_i) begin
      f_v    <= in_valid_i;
      f_op   <= in_op_i;
      f_rd   <= in_rd_i;
      f_rs1  <= in_rs1_i;
      f_rs2  <= in_rs2_i;
      f_last <= in_valid_i && in_last_i;
      d_valid_o <= f_v;
      d_op_o    <= f_op;
      d_rd_o    <= f_rd;
      d_rs1_o   <= f_rs1;
      d_rs2_o   <= f_rs2;
      d_last_o  <= f_v && f_last;
    end
  end

  // R11: decode contents hold across a stalled cycle
  a_r11_decode_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!advance_i && d_valid_o) |=> (d_valid_o && $stable(d_rd_o) && $stable(d_rs1_o)
                                   && $stable(d_rs2_o) && $stable(d_op_o)));
endmodule

// File: rtl/inorder_interlock.sv
module inorder_interlock
  import ilk_pkg::*;
#(
  parameter int REG_W   = 3,
  parameter int ADD_LAT = 4,
  parameter int MUL_LAT = 6,
  parameter int CNT_W   = 16,
  localparam int NREG   = 1 << REG_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_valid_i,
  input  logic             in_op_i,
  input  logic [REG_W-1:0] in_rd_i,
  input  logic [REG_W-1:0] in_rs1_i,
  input  logic [REG_W-1:0] in_rs2_i,
  input  logic             in_last_i,
  output logic             stall_o,
  output logic             issue_o,
  output logic             done_o,
  output logic [CNT_W-1:0] cycle_cnt_o
);
  logic             d_valid, d_last;
  op_e              d_op;
  logic [REG_W-1:0] d_rd, d_rs1, d_rs2;
  logic [NREG-1:0]  busy;
  logic             wb_conflict, pipe_busy, wb_valid;
  logic [REG_W-1:0] wb_rd;
  logic             hazard, last_issued_q, done_q;
  logic [CNT_W-1:0] cnt_q;

  ilk_front #(.REG_W(REG_W)) u_front (
    .clk_i, .rst_ni,
    .advance_i (!stall_o),
    .in_valid_i,
    .in_op_i   (op_e'(in_op_i)),
    .in_rd_i, .in_rs1_i, .in_rs2_i, .in_last_i,
    .d_valid_o (d_valid),
    .d_op_o    (d_op),
    .d_rd_o    (d_rd),
    .d_rs1_o   (d_rs1),
    .d_rs2_o   (d_rs2),
    .d_last_o  (d_last)
  );

  ilk_scoreboard #(.REG_W(REG_W)) u_sb (
    .clk_i, .rst_ni,
    .set_en_i  (issue_o),
    .set_idx_i (d_rd),
    .clr_en_i  (wb_valid),
    .clr_idx_i (wb_rd),
    .busy_o    (busy)
  );

  ilk_exec_pipe #(.REG_W(REG_W), .ADD_LAT(ADD_LAT), .MUL_LAT(MUL_LAT)) u_exec (
    .clk_i, .rst_ni,
    .issue_i       (issue_o),
    .op_i          (d_op),
    .rd_i          (d_rd),
    .wb_conflict_o (wb_conflict),
    .busy_o        (pipe_busy),
    .wb_valid_o    (wb_valid),
    .wb_rd_o       (wb_rd)
  );

  // read-after-write, write-after-write, writeback collision
  assign hazard  = busy[d_rs1] || busy[d_rs2] || busy[d_rd] || wb_conflict;
  assign issue_o = d_valid && !hazard;
  assign stall_o = d_valid && hazard;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_issued_q <= 1'b0;
      done_q        <= 1'b0;
      cnt_q         <= '0;
    end else begin
      if (issue_o && d_last) last_issued_q <= 1'b1;
      if (last_issued_q && wb_valid && !pipe_busy) done_q <= 1'b1;
      if (!done_q) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign done_o      = done_q;
  assign cycle_cnt_o = cnt_q;

  a_r11_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(stall_o && issue_o));
  a_r8_done_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> done_q);
  a_r9_count_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_q |=> cnt_q == $past(cnt_q) + 1'b1);
  a_r9_count_freeze: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> $stable(cnt_q));
  a_r2_decode_waits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !d_valid |-> !issue_o);
endmodule

// File: tb/sim_inorder_interlock.sv
module sim_inorder_interlock;
  localparam int REG_W = 3;
  localparam int CNT_W = 16;

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic             in_valid = 1'b0, in_op = 1'b0, in_last = 1'b0;
  logic [REG_W-1:0] in_rd = '0, in_rs1 = '0, in_rs2 = '0;
  logic             stall, issue, done;
  logic [CNT_W-1:0] cnt;

  int n_checks = 0, n_fail = 0;
  bit finished = 1'b0;

  logic             p_op  [8];
  logic [REG_W-1:0] p_rd  [8];
  logic [REG_W-1:0] p_rs1 [8];
  logic [REG_W-1:0] p_rs2 [8];
  int r_stalls, r_issues, r_cnt;
  bit r_done;

  always #4 clk = ~clk;

  inorder_interlock #(.REG_W(REG_W), .CNT_W(CNT_W)) u0 (
    .clk_i(clk), .rst_ni, .in_valid_i(in_valid), .in_op_i(in_op), .in_rd_i(in_rd),
    .in_rs1_i(in_rs1), .in_rs2_i(in_rs2), .in_last_i(in_last),
    .stall_o(stall), .issue_o(issue), .done_o(done), .cycle_cnt_o(cnt)
  );

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic put(input int i, input logic op, input int rd, input int rs1, input int rs2);
    p_op[i] = op; p_rd[i] = REG_W'(rd); p_rs1[i] = REG_W'(rs1); p_rs2[i] = REG_W'(rs2);
  endtask

  task automatic run_prog(input int n);
    int idx;
    bit acc;
    rst_ni = 1'b0; in_valid = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_ni = 1'b1;
    idx = 0; r_stalls = 0; r_issues = 0; r_done = 1'b0;
    for (int cyc = 0; cyc < 300; cyc++) begin
      in_valid = (idx < n);
      if (idx < n) begin
        in_op = p_op[idx]; in_rd = p_rd[idx]; in_rs1 = p_rs1[idx];
        in_rs2 = p_rs2[idx]; in_last = (idx == n - 1);
      end
      if (done) begin r_done = 1'b1; break; end
      if (issue) r_issues++;
      if (stall) r_stalls++;
      acc = in_valid && !stall;
      @(negedge clk);
      if (acc) idx++;
    end
    in_valid = 1'b0;
    r_cnt = int'(cnt);
  endtask

  task automatic expect_run(input string req, input int n, input int exp_cnt, input int exp_stall);
    run_prog(n);
    check({req, " done"}, int'(r_done), 1);
    check({req, " cycle count"}, r_cnt, exp_cnt);
    check({req, " stall cycles"}, r_stalls, exp_stall);
    check({req, " issues"}, r_issues, n);
  endtask

  task automatic t_reset;
    rst_ni = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R1 stall", int'(stall), 0);
    check("R1 issue", int'(issue), 0);
    check("R1 done", int'(done), 0);
    check("R1 count", int'(cnt), 0);
  endtask

  task automatic t_freeze;
    // R9: count holds after done
    int c0;
    c0 = int'(cnt);
    repeat (5) @(negedge clk);
    check("R9 frozen count", int'(cnt), c0);
    check("R8 done held", int'(done), 1);
  endtask

  initial begin
    t_reset();
    put(0, 1'b0, 1, 2, 3);                     expect_run("R2 R3 lone ADD", 1, 8, 0);
    t_freeze();
    put(0, 1'b1, 1, 2, 3);                     expect_run("R3 lone MUL", 1, 10, 0);
    put(0, 1'b0, 1, 2, 3); put(1, 1'b0, 4, 1, 5); expect_run("R4 ADD->ADD", 2, 14, 5);
    put(0, 1'b1, 6, 2, 3); put(1, 1'b0, 4, 5, 6); expect_run("R4 MUL->ADD rs2", 2, 16, 7);
    put(0, 1'b0, 1, 2, 3); put(1, 1'b0, 4, 5, 6); put(2, 1'b0, 7, 5, 6);
    expect_run("R7 independent", 3, 10, 0);
    put(0, 1'b1, 1, 2, 3); put(1, 1'b0, 4, 5, 6); put(2, 1'b0, 7, 5, 6);
    expect_run("R6 wb collision", 3, 11, 1);
    put(0, 1'b0, 4, 1, 2); put(1, 1'b0, 4, 2, 3); expect_run("R5 WAW", 2, 14, 5);
    put(0, 1'b0, 0, 1, 2); put(1, 1'b0, 5, 0, 3); expect_run("R10 reg0", 2, 14, 5);
    put(0, 1'b1, 1, 2, 3); put(1, 1'b0, 2, 4, 5); expect_run("R8 out-of-order finish", 2, 10, 0);
    put(0, 1'b0, 1, 2, 3); put(1, 1'b0, 4, 1, 5); put(2, 1'b0, 6, 4, 4);
    expect_run("R11 chained stalls", 3, 20, 10);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule